// File: doc/BRIEF.md
# Biased Pseudo-Random Stimulus Source

This block turns a maximal-length shift-register sequence into a single stimulus bit whose chance of being 1 can be tilted away from one half. On each enabled clock the raw register advances one step. A registered output bit is formed by ANDing between one and four spread-out register stages, which pulls the 1-probability down to 1/2, 1/4, 1/8 or 1/16. An optional inversion mirrors those figures to 3/4, 7/8 or 15/16. Self-test logic uses it to drive inputs that need mostly-0 or mostly-1 values, for example the enable or reset-like inputs of a circuit under test.

A seed can be loaded at any time. A zero seed would freeze the register, so it is replaced by a fixed nonzero default. The full register contents are also brought out for observation.

Top module: `wprpg`

## Requirements
- R1: While `rst` is high, at the next clock `state` becomes the default seed 8'h1D and `wbit` becomes 0.
- R2: When `load` is high and `seed` is nonzero, `state` equals `seed` after the clock edge. `load` takes priority over `enable`, and `wbit` keeps its value on a load cycle.
- R3: When `load` is high and `seed` is zero, `state` becomes the default seed 8'h1D.
- R4: When `load` and `enable` are both low, `state` and `wbit` keep their values.
- R5: With `enable` high, `state` steps as a left shift, with new bit 0 = state[7]^state[5]^state[4]^state[3]. This is the polynomial x^8+x^6+x^5+x^4+1. The sequence returns to its starting value after exactly 255 steps and never holds zero.
- R6: For `wt_sel`=0, `wbit` after an enabled edge equals state[0] from before that edge, and `invert` has no effect. Over one full period this gives 128 ones.
- R7: For `wt_sel`=1, `wbit` is state[0]&state[2], inverted when `invert`=1. Over one period this gives 64 ones, or 191 ones when inverted.
- R8: For `wt_sel`=2, `wbit` is state[0]&state[2]&state[4], inverted when `invert`=1. Over one period this gives 32 ones, or 223 ones when inverted.
- R9: For `wt_sel`=3, `wbit` is state[0]&state[2]&state[4]&state[6], inverted when `invert`=1. Over one period this gives 16 ones, or 239 ones when inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Advance the register and update the output bit |
| load | input | 1 | Load `seed` into the register |
| seed | input | 8 | Seed value; zero selects the default seed |
| wt_sel | input | 2 | Number of ANDed stages minus one |
| invert | input | 1 | Invert the combined bit (ignored when `wt_sel`=0) |
| wbit | output | 1 | Registered weighted stimulus bit |
| state | output | 8 | Raw register contents |

## Verification
Two functions can fall in the same cycle: a seed load and an enabled step. The bench raises `load` and `enable` together, once with a nonzero seed and once with a zero seed. It then judges that `state` took the seed or the default rather than the shifted value, and that `wbit` did not move. Outside those cycles, a scoreboard predicts every output bit and register value from the polynomial. It also checks the exact count of ones over a full 255-step period for each weight code and invert setting.

// File: rtl/wprpg_pkg.sv
package wprpg_pkg;
  localparam int unsigned WEIGHT_LEVELS = 4;
  localparam int unsigned WSEL_W        = $clog2(WEIGHT_LEVELS);

  typedef enum logic [WSEL_W-1:0] {
    W_HALF      = 2'd0,
    W_QUARTER   = 2'd1,
    W_EIGHTH    = 2'd2,
    W_SIXTEENTH = 2'd3
  } weight_e;
endpackage

// File: rtl/wprpg_lfsr.sv
module wprpg_lfsr #(
  parameter int unsigned WIDTH        = 8,
  parameter logic [WIDTH-1:0] TAPS    = 8'hB8,
  parameter logic [WIDTH-1:0] DEF_SEED = 8'h1D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] state_q
);
  logic feedback;
  logic [WIDTH-1:0] load_val;

  always_comb begin
    feedback = ^(state_q & TAPS);
    load_val = (seed == '0) ? DEF_SEED : seed;
  end

  always_ff @(posedge clk) begin
    if (rst)       state_q <= DEF_SEED;
    else if (load) state_q <= load_val;
    else if (step) state_q <= {state_q[WIDTH-2:0], feedback};
  end

  assert_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (load && seed != '0) |=> state_q == $past(seed));
  assert_zero_seed_R3: assert property (@(posedge clk) disable iff (rst)
    (load && seed == '0) |=> state_q == DEF_SEED);
  assert_state_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(state_q));
endmodule

// File: rtl/wprpg_shaper.sv
module wprpg_shaper
  import wprpg_pkg::*;
(
  input  logic [WEIGHT_LEVELS-1:0] taps,
  input  logic [WSEL_W-1:0]        wt_sel,
  input  logic                     invert,
  output logic                     shaped
);
  logic [WEIGHT_LEVELS-1:0] acc;
  logic                     picked;

  assign acc[0] = taps[0];
  for (genvar i = 1; i < WEIGHT_LEVELS; i++) begin : g_and_chain
    assign acc[i] = acc[i-1] & taps[i];
  end

  always_comb begin
    picked = acc[wt_sel];
    shaped = (invert && (wt_sel != W_HALF)) ? ~picked : picked;
  end
endmodule

// File: rtl/wprpg.sv
module wprpg
  import wprpg_pkg::*;
#(
  parameter int unsigned WIDTH         = 8,
  parameter logic [WIDTH-1:0] TAPS     = 8'hB8,
  parameter logic [WIDTH-1:0] DEF_SEED = 8'h1D,
  parameter int unsigned STAGE_STEP    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              load,
  input  logic [WIDTH-1:0]  seed,
  input  logic [WSEL_W-1:0] wt_sel,
  input  logic              invert,
  output logic              wbit,
  output logic [WIDTH-1:0]  state
);
  localparam int unsigned TOP_STAGE = (WEIGHT_LEVELS - 1) * STAGE_STEP;

  logic [WEIGHT_LEVELS-1:0] taps;
  logic                     shaped;
  logic                     wbit_q;

  if (TOP_STAGE >= WIDTH) begin : g_bad_cfg
    initial $error("stage spacing exceeds register width");
  end

  wprpg_lfsr #(.WIDTH(WIDTH), .TAPS(TAPS), .DEF_SEED(DEF_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .step(enable), .load(load), .seed(seed),
    .state_q(state)
  );

  for (genvar i = 0; i < WEIGHT_LEVELS; i++) begin : g_taps
    assign taps[i] = state[i*STAGE_STEP];
  end

  wprpg_shaper u_shaper (
    .taps(taps), .wt_sel(wt_sel), .invert(invert), .shaped(shaped)
  );

  always_ff @(posedge clk) begin
    if (rst)                  wbit_q <= 1'b0;
    else if (!load && enable) wbit_q <= shaped;
  end

  assign wbit = wbit_q;

  assert_wbit_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && !enable) |=> $stable(wbit));
  assert_load_keeps_wbit_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> $stable(wbit));
  assert_half_ignores_invert_R6: assert property (@(posedge clk) disable iff (rst)
    (enable && !load && wt_sel == W_HALF) |=> wbit == $past(state[0]));
  assert_sixteenth_R9: assert property (@(posedge clk) disable iff (rst)
    (enable && !load && wt_sel == W_SIXTEENTH && !invert) |=>
      wbit == ($past(state[0]) & $past(state[2]) & $past(state[4]) & $past(state[6])));
endmodule

// File: tb/wprpg_test.sv
module wprpg_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       load = 1'b0;
  logic [7:0] seed = 8'h00;
  logic [1:0] wt_sel = 2'd0;
  logic       invert = 1'b0;
  logic       wbit;
  logic [7:0] state;

  int checks = 0;
  int fails  = 0;
  int ones_acc = 0;
  logic [7:0] model;

  typedef struct {
    logic       w;
    logic [7:0] s;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  wprpg uut (.clk(clk), .rst(rst), .enable(enable), .load(load), .seed(seed),
             .wt_sel(wt_sel), .invert(invert), .wbit(wbit), .state(state));

  function automatic logic [7:0] nxt(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic shape(input logic [7:0] s, input logic [1:0] k, input logic inv);
    logic a;
    a = s[0];
    if (k >= 2'd1) a = a & s[2];
    if (k >= 2'd2) a = a & s[4];
    if (k >= 2'd3) a = a & s[6];
    return (inv && k != 2'd0) ? ~a : a;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops predictions shortly after each clock edge
  initial forever begin
    @(posedge clk);
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      if (wbit) ones_acc++;
      check(wbit === e.w, e.req, wbit, e.w);
      check(state === e.s && state != 8'h00, "R5", state, e.s);
    end
  end

  // driver: one enabled step with a pushed prediction
  task automatic step(input logic [1:0] k, input logic inv, input string req);
    exp_t e;
    enable = 1'b1; load = 1'b0; wt_sel = k; invert = inv;
    e.w = shape(model, k, inv);
    model = nxt(model);
    e.s = model;
    e.req = req;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic run_period(input logic [1:0] k, input logic inv, input int exp_ones, input string req);
    logic [7:0] start;
    start = state;
    ones_acc = 0;
    for (int i = 0; i < 255; i++) step(k, inv, req);
    enable = 1'b0;
    check(ones_acc == exp_ones, req, ones_acc, exp_ones);
    check(state == start, "R5", state, start);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(state == 8'h1D, "R1", state, 8'h1D);
    check(wbit == 1'b0, "R1", wbit, 0);
    rst = 1'b0;
    model = 8'h1D;

    // advance a bit so wbit gets a known value
    step(2'd0, 1'b0, "R6");
    step(2'd0, 1'b0, "R6");
    enable = 1'b0;

    // load with nonzero seed while enable high: load wins, wbit held
    begin
      logic wb;
      wb = wbit;
      load = 1'b1; enable = 1'b1; seed = 8'h3C;
      @(negedge clk);
      load = 1'b0; enable = 1'b0;
      check(state == 8'h3C, "R2", state, 8'h3C);
      check(wbit == wb, "R2", wbit, wb);
    end
    model = 8'h3C;

    // hold with enable low
    begin
      logic wb;
      logic [7:0] sv;
      step(2'd1, 1'b1, "R7");
      enable = 1'b0;
      wb = wbit; sv = state;
      repeat (3) @(negedge clk);
      check(state == sv, "R4", state, sv);
      check(wbit == wb, "R4", wbit, wb);
    end

    // zero seed with enable high: default seed
    begin
      logic wb;
      wb = wbit;
      load = 1'b1; enable = 1'b1; seed = 8'h00;
      @(negedge clk);
      load = 1'b0; enable = 1'b0;
      check(state == 8'h1D, "R3", state, 8'h1D);
      check(wbit == wb, "R3", wbit, wb);
    end
    model = 8'h1D;

    run_period(2'd0, 1'b0, 128, "R6");
    run_period(2'd0, 1'b1, 128, "R6");
    run_period(2'd1, 1'b0, 64,  "R7");
    run_period(2'd1, 1'b1, 191, "R7");
    run_period(2'd2, 1'b0, 32,  "R8");
    run_period(2'd2, 1'b1, 223, "R8");
    run_period(2'd3, 1'b0, 16,  "R9");
    run_period(2'd3, 1'b1, 239, "R9");

    // reset again mid-run
    rst = 1'b1;
    @(negedge clk);
    check(state == 8'h1D, "R1", state, 8'h1D);
    check(wbit == 1'b0, "R1", wbit, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule